// File: doc/BRIEF.md
# Dual-Line Interrupt Flag Router

This block keeps the interrupt status for a CAN-style controller in two 32-bit flag words with the same layout. Each word drives one interrupt output line. Controller-wide events and mailbox events are each steered into one of the two words. A single line-select input steers the controller-wide events. A per-mailbox select vector steers each mailbox's events. Software reads either word through a plain register port. It acknowledges edge-type flags by writing ones.

There are two kinds of flag. Six event flags are sticky: a one-cycle strobe sets them, and only a software write-one clears them. The other flags follow a level: the abort-acknowledge and lost-message status lines, plus a summary of pending and timed-out mailboxes. These level flags are mirrored into the words one cycle after the level changes. Each word also carries the number of the highest-numbered pending mailbox steered to its line. An interrupt line is raised while its word holds any set flag and its enable input is high.

Top module: `irq_flag_router`

## Requirements
- R1: After reset both flag words read 0 and both interrupt lines are low.
- R2: A strobe on `ev_set` bit i sets the sticky flag for event i at the next clock edge, in word 0 when `glb_line_sel`=0 and in word 1 when it is 1. The other word is left untouched. The bit order and flag positions are: i=0 counter overflow at bit 16, i=1 write denied at bit 13, i=2 wake-up at bit 12, i=3 bus-off at bit 10, i=4 error passive at bit 9, i=5 warning level at bit 8.
- R3: Bit 15 (mailbox pending) of word n is 1 one cycle after any mailbox j with `mbox_pend[j]`=1 and `mbox_line_sel[j]`=n. Bit 17 (mailbox timeout) of word n is 1 one cycle after any mailbox j with `mbox_tmo[j]`=1 and `mbox_line_sel[j]`=n. Otherwise each of these bits is 0.
- R4: A write with `reg_wr_en`=1 to word `reg_wr_sel` clears, at the next edge, each sticky flag whose bit is 1 in `reg_wr_data`.
- R5: Writing 0 to a sticky flag leaves it set. A write to one word leaves the other word unchanged. Writes never change bits 17, 15, 14 or 11, or the vector field.
- R6: If a sticky flag is set by a strobe and cleared by a write in the same cycle, the flag is 1 afterwards.
- R7: Bit 14 (abort acknowledge) and bit 11 (lost message) of the word chosen by `glb_line_sel` follow `aai_status` and `rml_status` with one cycle of delay. The same bits of the other word are 0.
- R8: Bits 4:0 of word n hold the highest index j with `mbox_pend[j]`=1 and `mbox_line_sel[j]`=n, one cycle after the inputs change. The field is 0 when no such mailbox exists.
- R9: Bits 31:18 and 7:5 of both words always read 0, whatever has been written.
- R10: `irq_line[n]` is 1 exactly when `line_en[n]`=1 and word n has any flag among bits 17:8 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the write-one-to-clear port |
| reg_wr_sel | input | 1 | Word targeted by the write (0 or 1) |
| reg_wr_data | input | 32 | Write data; a 1 clears the matching sticky flag |
| reg_rd_sel | input | 1 | Word presented on the read port |
| reg_rd_data | output | 32 | Selected flag word (combinational read) |
| glb_line_sel | input | 1 | Line choice for controller-wide events |
| ev_set | input | 6 | One-cycle strobes for the six sticky events |
| aai_status | input | 1 | Abort-acknowledge level status |
| rml_status | input | 1 | Lost-message level status |
| mbox_pend | input | 32 | Per-mailbox pending interrupt |
| mbox_tmo | input | 32 | Per-mailbox timeout status |
| mbox_line_sel | input | 32 | Per-mailbox line choice |
| line_en | input | 2 | Per-line interrupt enable |
| irq_line | output | 2 | Interrupt outputs, one per word |

## Verification
A fault in the routing or in the clear logic shows up as a flag in the wrong word, or as a flag that is stuck on or lost. Both the read port and the interrupt outputs expose this on the first edge after the stimulus. A fault in the mailbox summary shows up as a wrong vector or pending bit one cycle after a change to the pending or select inputs. For this reason the bench sweeps every mailbox on both lines, every sticky event on both lines, and mixed pending patterns, and reads both words after each step.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_W1C  = 6;
  localparam int VEC_FLD_W = 5;

  localparam int B_MTO = 17;
  localparam int B_TCO = 16;
  localparam int B_GMI = 15;
  localparam int B_AAI = 14;
  localparam int B_WDI = 13;
  localparam int B_WUI = 12;
  localparam int B_RML = 11;
  localparam int B_BOI = 10;
  localparam int B_EPI = 9;
  localparam int B_WLI = 8;

  localparam logic [REG_W-1:0] IRQ_SRC_MASK = 32'h0003_FF00;

  typedef struct packed {
    logic                 mto;
    logic                 gmi;
    logic                 aai;
    logic                 rml;
    logic [VEC_FLD_W-1:0] vec;
  } ro_fields_t;

  function automatic int w1c_pos(input int idx);
    case (idx)
      0:       return B_TCO;
      1:       return B_WDI;
      2:       return B_WUI;
      3:       return B_BOI;
      4:       return B_EPI;
      default: return B_WLI;
    endcase
  endfunction

  function automatic logic [NUM_W1C-1:0] w1c_from_word(input logic [REG_W-1:0] d);
    logic [NUM_W1C-1:0] r;
    for (int i = 0; i < NUM_W1C; i++) r[i] = d[w1c_pos(i)];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_flags(input logic [NUM_W1C-1:0] w,
                                                  input ro_fields_t r);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_W1C; i++) v[w1c_pos(i)] = w[i];
    v[B_MTO] = r.mto;
    v[B_GMI] = r.gmi;
    v[B_AAI] = r.aai;
    v[B_RML] = r.rml;
    v[VEC_FLD_W-1:0] = r.vec;
    return v;
  endfunction
endpackage

// File: rtl/global_steer.sv
module global_steer
  import irq_router_pkg::*;
(
  input  logic               line_sel,
  input  logic [NUM_W1C-1:0] ev_in,
  input  logic               aai_in,
  input  logic               rml_in,
  output logic [1:0][NUM_W1C-1:0] ev_out,
  output logic [1:0]         aai_out,
  output logic [1:0]         rml_out
);
  always_comb begin
    ev_out  = '0;
    aai_out = '0;
    rml_out = '0;
    ev_out[line_sel]  = ev_in;
    aai_out[line_sel] = aai_in;
    rml_out[line_sel] = rml_in;
  end
endmodule

// File: rtl/w1c_bank.sv
module w1c_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[b] <= 1'b0;
      else if (set_i[b])   q_o[b] <= 1'b1;
      else if (clr_i[b])   q_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_summary.sv
module mbox_summary
  import irq_router_pkg::*;
#(
  parameter int NUM_MBOX = 32,
  parameter bit LINE     = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MBOX-1:0] pend,
  input  logic [NUM_MBOX-1:0] tmo,
  input  logic [NUM_MBOX-1:0] line_sel,
  input  logic                aai_in,
  input  logic                rml_in,
  output ro_fields_t          q
);
  localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;

  function automatic logic [IDX_W-1:0] top_index(input logic [NUM_MBOX-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_MBOX; k++) if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  logic [NUM_MBOX-1:0] mine;
  logic [NUM_MBOX-1:0] pend_mine;
  logic [NUM_MBOX-1:0] tmo_mine;
  ro_fields_t          nxt;

  assign mine      = LINE ? line_sel : ~line_sel;
  assign pend_mine = pend & mine;
  assign tmo_mine  = tmo & mine;

  always_comb begin
    nxt     = '0;
    nxt.mto = |tmo_mine;
    nxt.gmi = |pend_mine;
    nxt.aai = aai_in;
    nxt.rml = rml_in;
    nxt.vec = VEC_FLD_W'(top_index(pend_mine));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_flag_router.sv
module irq_flag_router
  import irq_router_pkg::*;
#(
  parameter int NUM_MBOX = 32
) (
  input  logic                reg_wr_en,
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_sel,
  input  logic [REG_W-1:0]    reg_wr_data,
  input  logic                reg_rd_sel,
  output logic [REG_W-1:0]    reg_rd_data,
  input  logic                glb_line_sel,
  input  logic [NUM_W1C-1:0]  ev_set,
  input  logic                aai_status,
  input  logic                rml_status,
  input  logic [NUM_MBOX-1:0] mbox_pend,
  input  logic [NUM_MBOX-1:0] mbox_tmo,
  input  logic [NUM_MBOX-1:0] mbox_line_sel,
  input  logic [1:0]          line_en,
  output logic [1:0]          irq_line
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0][NUM_W1C-1:0] set_evt;
  logic [NUM_LINES-1:0]              aai_rt;
  logic [NUM_LINES-1:0]              rml_rt;
  logic [NUM_LINES-1:0][NUM_W1C-1:0] clr_req;
  logic [NUM_LINES-1:0][NUM_W1C-1:0] sticky_q;
  ro_fields_t                        ro_q [NUM_LINES];
  logic [NUM_LINES-1:0][REG_W-1:0]   flag_q;

  global_steer u_steer (
    .line_sel (glb_line_sel),
    .ev_in    (ev_set),
    .aai_in   (aai_status),
    .rml_in   (rml_status),
    .ev_out   (set_evt),
    .aai_out  (aai_rt),
    .rml_out  (rml_rt)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign clr_req[l] = (reg_wr_en && (reg_wr_sel == 1'(l))) ?
                        w1c_from_word(reg_wr_data) : '0;

    w1c_bank #(.N(NUM_W1C)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_evt[l]),
      .clr_i (clr_req[l]),
      .q_o   (sticky_q[l])
    );

    mbox_summary #(.NUM_MBOX(NUM_MBOX), .LINE(1'(l))) u_mbox (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (mbox_pend),
      .tmo      (mbox_tmo),
      .line_sel (mbox_line_sel),
      .aai_in   (aai_rt[l]),
      .rml_in   (rml_rt[l]),
      .q        (ro_q[l])
    );

    assign flag_q[l]   = pack_flags(sticky_q[l], ro_q[l]);
    assign irq_line[l] = line_en[l] && |(flag_q[l] & IRQ_SRC_MASK);
  end

  assign reg_rd_data = flag_q[reg_rd_sel];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_MBOX = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      glb_line_sel,
  input logic [NUM_W1C-1:0]        ev_set,
  input logic                      reg_wr_en,
  input logic                      reg_wr_sel,
  input logic [REG_W-1:0]          reg_wr_data,
  input logic [1:0]                line_en,
  input logic [1:0]                irq_line,
  input logic [NUM_MBOX-1:0]       mbox_pend,
  input logic [NUM_MBOX-1:0]       mbox_line_sel,
  input logic [1:0][REG_W-1:0]     flag_q
);
  logic wr0, wr1;
  assign wr0 = reg_wr_en && !reg_wr_sel;
  assign wr1 = reg_wr_en && reg_wr_sel;

  p_route0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[0] && !glb_line_sel |=> flag_q[0][B_TCO]);
  p_route1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[0] && glb_line_sel |=> flag_q[1][B_TCO]);
  p_gmi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mbox_pend & ~mbox_line_sel)) |=> flag_q[0][B_GMI]);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 && reg_wr_data[B_WLI] && !ev_set[5] |=> !flag_q[0][B_WLI]);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[1][B_WDI] && !(wr1 && reg_wr_data[B_WDI]) |=> flag_q[1][B_WDI]);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[0] && !glb_line_sel && wr0 && reg_wr_data[B_TCO] |=> flag_q[0][B_TCO]);
  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q[1][B_GMI] |-> flag_q[1][4:0] == 5'd0);
  p_line_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en[1] |-> !irq_line[1]);
  p_line_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_en[0] && flag_q[0][B_WLI] |-> irq_line[0]);
endmodule

bind irq_flag_router irq_router_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .glb_line_sel  (glb_line_sel),
  .ev_set        (ev_set),
  .reg_wr_en     (reg_wr_en),
  .reg_wr_sel    (reg_wr_sel),
  .reg_wr_data   (reg_wr_data),
  .line_en       (line_en),
  .irq_line      (irq_line),
  .mbox_pend     (mbox_pend),
  .mbox_line_sel (mbox_line_sel),
  .flag_q        (flag_q)
);

// File: tb/sim_irq_flag_router.sv
module sim_irq_flag_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0, reg_rd_sel = 1'b0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic        glb_line_sel = 1'b0;
  logic [5:0]  ev_set = '0;
  logic        aai_status = 1'b0, rml_status = 1'b0;
  logic [31:0] mbox_pend = '0, mbox_tmo = '0, mbox_line_sel = '0;
  logic [1:0]  line_en = '0, irq_line;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_flag_router u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    reg_rd_sel = s;
    #1;
    v = reg_rd_data;
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_sel = s; reg_wr_data = d;
    step();
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  function automatic int bpos(input int i);
    int t[6] = '{16, 13, 12, 10, 9, 8};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] pend, input logic [31:0] sel,
                                           input logic line);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++)
      if (pend[k] && sel[k] == line) begin v[15] = 1'b1; v[4:0] = 5'(k); end
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v0, v1;
    logic [31:0] pats [3];
    logic [31:0] sels [3];
    pats = '{32'hA5C3_0F81, 32'h0000_0006, 32'h8000_0001};
    sels = '{32'h3C3C_F0F0, 32'h0000_0004, 32'h8000_0000};
    step(); step();
    rst_n = 1'b1;
    step();
    rd(0, v0); rd(1, v1);
    chk("R1 word0", v0, 0); chk("R1 word1", v1, 0);
    chk("R1 irq", {30'd0, irq_line}, 0);

    line_en = 2'b11;
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 6; e++) begin
        glb_line_sel = g[0]; ev_set = 6'(1 << e);
        step(); ev_set = '0;
        rd(g[0], v0); rd(!g[0], v1);
        chk("R2 routed word", v0, 32'(1) << bpos(e));
        chk("R2 other word", v1, 0);
        chk("R10 irq", {30'd0, irq_line}, 32'(1) << g);
        wr(g[0], ~(32'(1) << bpos(e)));
        wr(!g[0], 32'(1) << bpos(e));
        rd(g[0], v0);
        chk("R5 zero write keeps flag", v0, 32'(1) << bpos(e));
        wr(g[0], 32'(1) << bpos(e));
        rd(g[0], v0);
        chk("R4 cleared", v0, 0);
      end
    end

    glb_line_sel = 1'b0; ev_set = 6'b000001;
    reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 32'h0001_0000;
    step(); ev_set = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
    rd(0, v0);
    chk("R6 set wins", v0, 32'h0001_0000);
    wr(0, 32'hFFFF_FFFF);

    aai_status = 1'b1; glb_line_sel = 1'b0;
    step();
    rd(0, v0); rd(1, v1);
    chk("R7 aai word0", v0, 32'h0000_4000); chk("R7 aai word1", v1, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v0);
    chk("R5 read-only bit", v0, 32'h0000_4000);
    aai_status = 1'b0; step();
    rd(0, v0); chk("R7 aai released", v0, 0);
    rml_status = 1'b1; glb_line_sel = 1'b1;
    step();
    rd(0, v0); rd(1, v1);
    chk("R7 rml word0", v0, 0); chk("R7 rml word1", v1, 32'h0000_0800);
    rml_status = 1'b0; step();

    line_en = 2'b00;
    for (int i = 0; i < 32; i++) begin
      for (int s = 0; s < 2; s++) begin
        mbox_line_sel = s[0] ? '1 : '0;
        mbox_pend = 32'(1) << i; mbox_tmo = 32'(1) << i;
        step();
        rd(s[0], v0); rd(!s[0], v1);
        chk("R3/R8 mailbox word", v0, 32'h0002_8000 | 32'(i));
        chk("R3 other word", v1, 0);
      end
    end
    chk("R10 disabled lines", {30'd0, irq_line}, 0);
    mbox_tmo = '0;

    for (int p = 0; p < 3; p++) begin
      mbox_pend = pats[p]; mbox_line_sel = sels[p];
      step();
      rd(0, v0); rd(1, v1);
      chk("R8 mixed word0", v0, exp_word(pats[p], sels[p], 1'b0));
      chk("R8 mixed word1", v1, exp_word(pats[p], sels[p], 1'b1));
    end
    line_en = 2'b10;
    #1;
    chk("R10 single enable", {30'd0, irq_line}, 32'd2);

    glb_line_sel = 1'b0; ev_set = '1; aai_status = 1'b1; rml_status = 1'b1;
    mbox_pend = '1; mbox_tmo = '1; mbox_line_sel = 32'h5555_5555;
    step(); ev_set = '0;
    wr(1, 32'hFFFF_FFFF);
    rd(0, v0); rd(1, v1);
    chk("R9 reserved word0", v0 & 32'hFFFC_00E0, 0);
    chk("R9 reserved word1", v1 & 32'hFFFC_00E0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule